// File: doc/BRIEF.md
# Pipelined Converter Digital Error Correction

This block is the digital back end of a nine-stage pipelined analog-to-digital converter. On every rising clock edge each stage of the analog pipeline hands over a two-bit coarse decision. A given analog sample reaches the later stages later, so the stage decisions for one sample arrive at staggered times. The block delays each stage's code by its own amount so that all nine decisions for one sample meet in a single cycle. It then merges them by overlap-add over their redundant range, clamps the result to ten bits and registers it as an offset-binary word.

Stages 1 to 8 are 1.5-bit stages: code 0, 1 or 2 stands for a digit of -1, 0 or +1. Stage 9 is a plain two-bit flash, and all four of its codes are legal. The redundancy lets later stages repair decision errors made earlier, so every output code stays reachable. Two controls sit around the datapath. An active-low output enable lets the data be driven or released, with the released state shown by a drive flag. A power-down input quiets the outputs and flushes the pipeline. A data-valid flag marks the words that are free of any conversion that began during reset or power-down.

Top module: `adc_err_corr`

## Requirements
- R1: The code of stage i (i = 1..9) occupies bits [2i-1:2i-2] of `stage_code`. For one sample, the code of stage i is presented floor((i-1)/2) cycles after the code of stage 1.
- R2: The word for a sample appears on `dout` just after the 5th rising edge following the edge that captured its stage-1 code.
- R3: With c1..c9 the aligned codes, the unclamped result is 512 + sum over i=1..8 of (c_i - 1)*2^(10-i), plus c9. Stages 1..8 at code 1 with stage 9 at code 0 give 1000000000.
- R4: A result below 0 is output as 0, and a result above 1023 is output as 1023. The output never wraps.
- R5: Code 3 on any of stages 1..8 is weighted exactly as code 2. Code 3 on stage 9 adds 3.
- R6: While `oe_n` is 1, `dout_drive` is 0 and `dout` reads 0. While `oe_n` and `pwrdn` are both 0, `dout_drive` is 1.
- R7: In any cycle with `pwrdn` at 1, `dout_drive`, `dout` and `data_valid` are all 0.
- R8: `data_valid` is 0 during reset and during power-down. It becomes 1 only after 6 consecutive rising edges with both `rst` and `pwrdn` at 0. The five words that follow a release are therefore flagged invalid.
- R9: `oe_n` does not disturb the conversion stream or `data_valid`. Words are correct again in the first cycle after it returns to 0.
- R10: The reset is synchronous and active high. After a reset edge the output word is 0 and all delay lines are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| stage_code | input | 18 | Two-bit decisions of stages 1..9, stage 1 in the low bits |
| oe_n | input | 1 | Output enable, active low |
| pwrdn | input | 1 | Power-down request, active high |
| dout | output | 10 | Corrected offset-binary word, 0 when not driven |
| dout_drive | output | 1 | 1 when the data outputs are driven, 0 for high impedance |
| data_valid | output | 1 | 1 when `dout` carries a fully clean conversion |

## Verification
Clamping and the end of the invalid window can land in the same cycle. To force this, power-down is released and the very first sample converted afterwards is driven to positive over-range, followed by one at negative over-range. The bench requires `data_valid` to stay low for five cycles and rise in exactly the cycle where `dout` shows 1023, with 0 one cycle later. A word flagged valid but still holding flushed codes, or a late flag, therefore shows up as a mismatch.

// File: rtl/adc_ec_pkg.sv
package adc_ec_pkg;

    typedef logic [1:0] stage_code_t;

    // Cycles by which a stage's decision trails the first stage's decision.
    function automatic int stage_skew(input int stage_idx, input int per_step);
        return stage_idx / per_step;
    endfunction

    // 1.5-bit stages: the unused code is weighted like the top digit.
    function automatic stage_code_t fold_code(input stage_code_t c);
        return (c == 2'd3) ? 2'd2 : c;
    endfunction

endpackage

// File: rtl/adc_ec_align.sv
module adc_ec_align
    import adc_ec_pkg::*;
#(
    parameter int STAGES          = 9,
    parameter int STAGES_PER_SKEW = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  flush,
    input  logic [2*STAGES-1:0]   raw,
    output logic [2*STAGES-1:0]   aligned
);
    localparam int MAX_SKEW = stage_skew(STAGES - 1, STAGES_PER_SKEW);

    for (genvar g = 0; g < STAGES; g++) begin : g_lane
        localparam int DEPTH = MAX_SKEW - stage_skew(g, STAGES_PER_SKEW) + 1;

        stage_code_t pipe_d [DEPTH];
        stage_code_t pipe_q [DEPTH];

        always_comb begin
            for (int k = 0; k < DEPTH; k++) begin
                pipe_d[k] = '0;
            end
            if (!(rst || flush)) begin
                pipe_d[0] = raw[2*g +: 2];
                for (int k = 1; k < DEPTH; k++) begin
                    pipe_d[k] = pipe_q[k-1];
                end
            end
        end

        always_ff @(posedge clk) begin
            pipe_q <= pipe_d;
        end

        assign aligned[2*g +: 2] = pipe_q[DEPTH-1];
    end

    // R1: the last stage passes through a single register.
    a_r1_last_lane: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(flush)) |->
            (aligned[2*STAGES-1 -: 2] == $past(raw[2*STAGES-1 -: 2])));

endmodule

// File: rtl/adc_ec_merge.sv
module adc_ec_merge
    import adc_ec_pkg::*;
#(
    parameter int STAGES = 9
) (
    input  logic [2*STAGES-1:0] aligned,
    output logic [STAGES:0]     value
);
    localparam int OUT_W  = STAGES + 1;
    localparam int SUM_W  = OUT_W + 2;
    localparam int OFFSET = (1 << (OUT_W - 1)) - 4;
    localparam int TOP    = (1 << OUT_W) - 1;

    logic [SUM_W-1:0] acc;
    logic [SUM_W-1:0] shifted;
    stage_code_t      c;

    always_comb begin
        acc = '0;
        c   = '0;
        for (int i = 0; i < STAGES - 1; i++) begin
            c   = fold_code(aligned[2*i +: 2]);
            acc = acc + (SUM_W'(c) << (OUT_W - 1 - i));
        end
        acc = acc + SUM_W'(aligned[2*STAGES-1 -: 2]);

        shifted = acc - SUM_W'(OFFSET);
        if (acc < SUM_W'(OFFSET)) begin
            value = '0;
        end else if (shifted > SUM_W'(TOP)) begin
            value = OUT_W'(TOP);
        end else begin
            value = shifted[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/adc_ec_valid.sv
module adc_ec_valid #(
    parameter int VALID_AT = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic pwrdn,
    output logic live
);
    localparam int CNT_W = $clog2(VALID_AT + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             live;
    } run_state_t;

    run_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst || pwrdn) begin
            st_d.cnt  = '0;
            st_d.live = 1'b0;
        end else if (st_q.cnt != CNT_W'(VALID_AT)) begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.live = (st_q.cnt + 1'b1) == CNT_W'(VALID_AT);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign live = st_q.live;

    // R8: the flag can only be up once the counter has finished its run.
    a_r8_live_after_run: assert property (@(posedge clk) disable iff (rst)
        live |-> (st_q.cnt == CNT_W'(VALID_AT)));

endmodule

// File: rtl/adc_err_corr.sv
module adc_err_corr
    import adc_ec_pkg::*;
#(
    parameter int STAGES          = 9,
    parameter int STAGES_PER_SKEW = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [2*STAGES-1:0]   stage_code,
    input  logic                  oe_n,
    input  logic                  pwrdn,
    output logic [STAGES:0]       dout,
    output logic                  dout_drive,
    output logic                  data_valid
);
    localparam int OUT_W    = STAGES + 1;
    localparam int MAX_SKEW = stage_skew(STAGES - 1, STAGES_PER_SKEW);
    localparam int LATENCY  = MAX_SKEW + 1;
    localparam logic [2*STAGES-1:0] MID_PAT = {2'b00, {(STAGES-1){2'b01}}};

    typedef struct packed {
        logic [OUT_W-1:0] word;
    } out_state_t;

    logic [2*STAGES-1:0] aligned;
    logic [OUT_W-1:0]    merged;
    logic                live;
    out_state_t          out_d, out_q;

    adc_ec_align #(
        .STAGES          (STAGES),
        .STAGES_PER_SKEW (STAGES_PER_SKEW)
    ) u_align (
        .clk     (clk),
        .rst     (rst),
        .flush   (pwrdn),
        .raw     (stage_code),
        .aligned (aligned)
    );

    adc_ec_merge #(
        .STAGES (STAGES)
    ) u_merge (
        .aligned (aligned),
        .value   (merged)
    );

    adc_ec_valid #(
        .VALID_AT (LATENCY + 1)
    ) u_valid (
        .clk   (clk),
        .rst   (rst),
        .pwrdn (pwrdn),
        .live  (live)
    );

    always_comb begin
        out_d.word = merged;
        if (rst || pwrdn) begin
            out_d.word = '0;
        end
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign dout_drive = !oe_n && !pwrdn;
    assign dout       = dout_drive ? out_q.word : '0;
    assign data_valid = live && !pwrdn;

    // R7: power-down silences every output in the same cycle.
    a_r7_pwrdn_quiet: assert property (@(posedge clk) disable iff (rst)
        pwrdn |-> (!dout_drive && dout == '0 && !data_valid));

    // R6: a released bus reads as zero.
    a_r6_oe_quiet: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (!dout_drive && dout == '0));

    // R8: a valid word never follows an edge taken in power-down.
    a_r8_valid_clean: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> !$past(pwrdn));

    // R3: mid-scale decisions give the offset-binary midpoint.
    a_r3_mid_code: assert property (@(posedge clk) disable iff (rst)
        (!pwrdn && aligned == MID_PAT) |=> (out_q.word == OUT_W'(1 << (OUT_W - 1))));

    // R4: two leading high digits saturate at the top.
    a_r4_clamp_hi: assert property (@(posedge clk) disable iff (rst)
        (!pwrdn && aligned[1:0] >= 2'd2 && aligned[3:2] >= 2'd2) |=> (out_q.word == '1));

    // R4: two leading low digits saturate at the bottom.
    a_r4_clamp_lo: assert property (@(posedge clk) disable iff (rst)
        (!pwrdn && aligned[3:0] == 4'd0) |=> (out_q.word == '0));

endmodule

// File: tb/tb_adc_err_corr.sv
module tb_adc_err_corr;
    localparam int ST = 9;
    localparam int W  = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            oe_n = 1'b0;
    logic            pwrdn = 1'b0;
    logic [2*ST-1:0] stage_code = '0;
    logic [W-1:0]    dout;
    logic            dout_drive;
    logic            data_valid;

    int checks = 0;
    int failures = 0;
    int sc [64][ST];

    always #10 clk = ~clk;

    adc_err_corr dut (
        .clk        (clk),
        .rst        (rst),
        .stage_code (stage_code),
        .oe_n       (oe_n),
        .pwrdn      (pwrdn),
        .dout       (dout),
        .dout_drive (dout_drive),
        .data_valid (data_valid)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // R3/R5 arithmetic from the requirement text, before clamping.
    function automatic int raw_value(input int s);
        int v = 512;
        for (int i = 0; i < ST - 1; i++) begin
            int c = (sc[s][i] == 3) ? 2 : sc[s][i];
            v += (c - 1) * (1 << (9 - i));
        end
        return v + sc[s][ST-1];
    endfunction

    function automatic int expect_word(input int s);
        int v = raw_value(s);
        if (v < 0) return 0;
        if (v > 1023) return 1023;
        return v;
    endfunction

    function automatic string tag_of(input int s);
        int v = raw_value(s);
        bit three = 1'b0;
        for (int i = 0; i < ST - 1; i++) if (sc[s][i] == 3) three = 1'b1;
        if (v < 0 || v > 1023) return "R1 R2 R4 clamp";
        if (three) return "R1 R2 R5 code3";
        return "R1 R2 R3 merge";
    endfunction

    task automatic fill(input int n, input int pat);
        for (int s = 0; s < n; s++) begin
            int h = s + pat * 17;
            for (int i = 0; i < ST - 1; i++) begin
                sc[s][i] = (h * 7 + i * 5 + h / 3) % 3;
                if ((h * 3 + i) % 13 == 0) sc[s][i] = 3;
            end
            sc[s][ST-1] = (h * 5 + 1) % 4;
            if (s % 8 == 3) begin
                for (int i = 0; i < ST - 1; i++) sc[s][i] = 1;
                sc[s][ST-1] = 0;
            end
            if (pat == 2 && s == 0) begin
                for (int i = 0; i < ST; i++) sc[s][i] = 2;
            end
            if (pat == 2 && s == 1) begin
                for (int i = 0; i < ST; i++) sc[s][i] = 0;
            end
        end
    endtask

    // Drives n samples with the R1 stagger and checks each word 5 edges on.
    task automatic run_stream(input int n, input int oe_from, input int oe_to, input bit fresh);
        for (int t = 0; t < n + 6; t++) begin
            @(negedge clk);
            rst   = 1'b0;
            pwrdn = 1'b0;
            oe_n  = (t >= oe_from && t < oe_to);
            for (int i = 0; i < ST; i++) begin
                int s = t - i / 2;
                int c = (s >= 0 && s < n) ? sc[s][i] : ((i == ST - 1) ? 0 : 1);
                stage_code[2*i +: 2] = c[1:0];
            end
            #1;
            if (oe_n) begin
                check("R6 dout_drive released", int'(dout_drive), 0);
                check("R6 dout released", int'(dout), 0);
                check("R9 data_valid under oe_n", int'(data_valid), 1);
            end else begin
                if (fresh && t < 6)
                    check("R8 invalid window", int'(data_valid), (t >= 6) ? 1 : 0);
                else
                    check("R8 R9 data_valid held", int'(data_valid), 1);
                check("R6 dout_drive driven", int'(dout_drive), 1);
                if (t >= 6 && t - 6 < n)
                    check(tag_of(t - 6), int'(dout), expect_word(t - 6));
            end
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        rst = 1'b1;
        oe_n = 1'b0;
        pwrdn = 1'b0;
        stage_code = '1;
        repeat (2) @(negedge clk);
        #1;
        check("R10 dout after reset", int'(dout), 0);
        check("R10 dout_drive after reset", int'(dout_drive), 1);
        check("R8 data_valid in reset", int'(data_valid), 0);
        fill(40, 0);
        run_stream(40, -1, -1, 1'b1);
    endtask

    task automatic test_oe();
        fill(24, 1);
        run_stream(24, 10, 14, 1'b0);
    endtask

    // Clamp and the end of the invalid window fall into one cycle.
    task automatic test_pwrdn();
        @(negedge clk);
        pwrdn = 1'b1;
        #1;
        check("R7 dout_drive in power-down", int'(dout_drive), 0);
        check("R7 dout in power-down", int'(dout), 0);
        check("R7 data_valid in power-down", int'(data_valid), 0);
        repeat (3) begin
            @(negedge clk);
            #1;
            check("R7 data_valid held low", int'(data_valid), 0);
            check("R7 dout held zero", int'(dout), 0);
        end
        fill(16, 2);
        run_stream(16, -1, -1, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R2 actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        test_oe();
        test_pwrdn();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule